// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is one 32-pin general-purpose I/O bank behind a simple memory-mapped read/write port. Each pin has one bit in each register word. The bank stores output data and output-enable bits and drives them straight to the pads. It synchronises the pad inputs and exposes them as a read-only word. It also watches every pin for an interrupt condition. The condition is picked per pin by a level-select bit and a polarity bit, and matches are latched into sticky status bits.

Each register occupies a 16-byte slot. Software can write the slot's first word to load the register. It can write the second word to set the bits given as one, or the third word to clear the bits given as one. This lets firmware change single pins without a read-modify-write. The status word accepts only the clear form. A single bank interrupt line is high whenever an enabled status bit is set. Firmware can get detection on both edges by flipping a pin's polarity bit each time it services that pin.

Top module: `gpio_bank`

## Requirements
- R1: Synchronous reset, active high, clears every stored register, the synchroniser, the edge history and the status bits. After reset, pin_out, pin_oe and irq_out are all zero.
- R2: bus_addr[6:4] selects the register slot: 0 output data, 1 input (read-only), 2 output enable, 3 pin-to-interrupt select, 4 interrupt enable, 5 level select, 6 polarity, 7 status. bus_addr[3:2] selects the access form. A write with bus_addr[3:2]=0 loads the written word into a writable register on the next clock edge.
- R3: A write with bus_addr[3:2]=1 ORs the written word into the register. Bits written as zero are unchanged.
- R4: A write with bus_addr[3:2]=2 clears the register bits written as one. Bits written as zero are unchanged.
- R5: Writes with bus_addr[3:2]=3, or with bus_addr[7]=1, change nothing. A read of any word in a slot returns that register, with no cycle of latency. A read with bus_addr[7]=1 returns zero.
- R6: The input register shows pin_in after two clock edges and ignores every write.
- R7: pin_out equals the output data register and pin_oe equals the output enable register. Both registers read back as written.
- R8: In edge mode (level bit 0), a polarity bit of 1 latches status on a rising edge and a polarity bit of 0 latches status on a falling edge. The status bit becomes visible on the third clock edge after the pin changes.
- R9: In level mode (level bit 1), a polarity bit of 1 sets status while the pin is high and a polarity bit of 0 sets status while the pin is low. A clear has no lasting effect while the level condition holds.
- R10: A pin whose pin-to-interrupt select bit is 0 never sets its status bit.
- R11: Status bits are cleared only through the clear form. Load-form and set-form writes to the status slot are ignored.
- R12: irq_out is 1 exactly when status AND interrupt enable is non-zero. A status bit with its enable bit at 0 stays readable but does not raise irq_out.
- R13: A change to a pin's polarity bit while the pin is armed applies from the next synchronised sample onward. This allows detection on both edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 8 | Byte address: slot in [6:4], access form in [3:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | 32 | Asynchronous pad inputs |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Per-pin output enable |
| irq_out | output | 1 | Bank interrupt line |

## Verification
The register access forms are driven with mixed bit patterns whose set and cleared bits overlap the register's current contents. Any mix-up between load, set and clear therefore gives a different read-back value, and patterns sent to the reserved form and to out-of-range addresses must leave the registers unchanged. Detection is tried with rising and falling edges under each polarity, with held high and low levels in level mode, and with an unrouted pin. Together these separate edge sense from level sense and show that routing gates the status. The sample count at which the input word and the status change pins down the pipeline depth. A polarity flip on a pin that is already high shows that the next edge is judged with the new sense.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int GPIO_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int KIND_LSB  = 2;
    localparam int KIND_W    = 2;
    localparam int SEL_LSB   = 4;
    localparam int SEL_W     = 3;
    localparam int NUM_REGS  = 1 << SEL_W;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [SEL_W-1:0] {
        REG_DOUT  = 3'd0,
        REG_DIN   = 3'd1,
        REG_OE    = 3'd2,
        REG_ROUTE = 3'd3,
        REG_IEN   = 3'd4,
        REG_LEVEL = 3'd5,
        REG_POL   = 3'd6,
        REG_STAT  = 3'd7
    } reg_sel_e;

    typedef enum logic [KIND_W-1:0] {
        ACC_LOAD = 2'd0,
        ACC_SET  = 2'd1,
        ACC_CLR  = 2'd2,
        ACC_NONE = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic      valid;
        reg_sel_e  sel;
        acc_kind_e kind;
    } bus_dec_t;

    function automatic bus_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        bus_dec_t d;
        d.valid = ((a >> (SEL_LSB + SEL_W)) == '0);
        d.sel   = reg_sel_e'(a[SEL_LSB +: SEL_W]);
        d.kind  = acc_kind_e'(a[KIND_LSB +: KIND_W]);
        return d;
    endfunction

    function automatic logic [GPIO_W-1:0] apply_write(
        input logic [GPIO_W-1:0] old_val,
        input logic [GPIO_W-1:0] wd,
        input acc_kind_e         kind
    );
        case (kind)
            ACC_LOAD: return wd;
            ACC_SET:  return old_val | wd;
            ACC_CLR:  return old_val & ~wd;
            default:  return old_val;
        endcase
    endfunction

    function automatic bit reg_writable(input int r);
        return !(r == int'(REG_DIN) || r == int'(REG_STAT));
    endfunction

    function automatic logic sense_hit(
        input logic lvl,
        input logic pol,
        input logic cur,
        input logic prev
    );
        if (lvl)
            return ~(cur ^ pol);
        else if (pol)
            return cur & ~prev;
        else
            return ~cur & prev;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [GPIO_W-1:0] wdata,
    input  logic [GPIO_W-1:0] din_sync,
    input  logic [GPIO_W-1:0] status_in,
    output logic [GPIO_W-1:0] rdata,
    output logic [GPIO_W-1:0] dout_q,
    output logic [GPIO_W-1:0] oe_q,
    output logic [GPIO_W-1:0] route_q,
    output logic [GPIO_W-1:0] ien_q,
    output logic [GPIO_W-1:0] level_q,
    output logic [GPIO_W-1:0] pol_q,
    output logic [GPIO_W-1:0] stat_clr_mask
);
    bus_dec_t          dec;
    logic [GPIO_W-1:0] view [NUM_REGS];

    assign dec = decode_addr(addr);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        if (reg_writable(r)) begin : g_rw
            logic [GPIO_W-1:0] q;
            logic              hit;
            assign hit = wr_en && dec.valid && (dec.kind != ACC_NONE)
                         && (int'(dec.sel) == r);
            always_ff @(posedge clk) begin
                if (rst)      q <= '0;
                else if (hit) q <= apply_write(q, wdata, dec.kind);
            end
            assign view[r] = q;
        end else if (r == int'(REG_DIN)) begin : g_din
            assign view[r] = din_sync;
        end else begin : g_stat
            assign view[r] = status_in;
        end
    end

    assign rdata   = dec.valid ? view[dec.sel] : '0;
    assign dout_q  = view[REG_DOUT];
    assign oe_q    = view[REG_OE];
    assign route_q = view[REG_ROUTE];
    assign ien_q   = view[REG_IEN];
    assign level_q = view[REG_LEVEL];
    assign pol_q   = view[REG_POL];

    assign stat_clr_mask = (wr_en && dec.valid && dec.sel == REG_STAT
                            && dec.kind == ACC_CLR) ? wdata : '0;

    // R2
    oe_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.valid && dec.sel == REG_OE && dec.kind == ACC_LOAD)
        |=> (oe_q == $past(wdata)));

    // R3
    pol_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.valid && dec.sel == REG_POL && dec.kind == ACC_SET)
        |=> (pol_q == ($past(pol_q) | $past(wdata))));

    // R4
    dout_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.valid && dec.sel == REG_DOUT && dec.kind == ACC_CLR)
        |=> (dout_q == ($past(dout_q) & ~$past(wdata))));

    // R5
    reserved_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (!dec.valid || dec.kind == ACC_NONE))
        |=> ($stable(dout_q) && $stable(oe_q) && $stable(route_q)
             && $stable(ien_q) && $stable(level_q) && $stable(pol_q)));
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [GPIO_W-1:0] cur,
    input  logic [GPIO_W-1:0] route,
    input  logic [GPIO_W-1:0] level,
    input  logic [GPIO_W-1:0] pol,
    input  logic [GPIO_W-1:0] ien,
    input  logic [GPIO_W-1:0] clr_mask,
    output logic [GPIO_W-1:0] status_q,
    output logic              irq_out
);
    logic [GPIO_W-1:0] prev_q;
    logic [GPIO_W-1:0] hit;

    for (genvar p = 0; p < GPIO_W; p++) begin : g_pin
        assign hit[p] = route[p] & sense_hit(level[p], pol[p], cur[p], prev_q[p]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            status_q <= '0;
        end else begin
            prev_q   <= cur;
            status_q <= (status_q & ~clr_mask) | hit;
        end
    end

    assign irq_out = |(status_q & ien);

    // R10
    status_route_chk: assert property (@(posedge clk) disable iff (rst)
        ((status_q & ~$past(status_q) & ~$past(route)) == '0));

    // R11
    status_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ((($past(status_q) & ~status_q) & ~$past(clr_mask)) == '0));

    // R9
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((status_q & $past(route & level & ~(cur ^ pol)))
         == $past(route & level & ~(cur ^ pol))));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [GPIO_W-1:0] bus_wdata,
    output logic [GPIO_W-1:0] bus_rdata,
    input  logic [GPIO_W-1:0] pin_in,
    output logic [GPIO_W-1:0] pin_out,
    output logic [GPIO_W-1:0] pin_oe,
    output logic              irq_out
);
    logic [GPIO_W-1:0] din_sync;
    logic [GPIO_W-1:0] status;
    logic [GPIO_W-1:0] route, ien, level, pol, clr_mask;

    gpio_sync #(
        .WIDTH  (GPIO_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (din_sync)
    );

    gpio_regs u_regs (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (bus_wr),
        .addr          (bus_addr),
        .wdata         (bus_wdata),
        .din_sync      (din_sync),
        .status_in     (status),
        .rdata         (bus_rdata),
        .dout_q        (pin_out),
        .oe_q          (pin_oe),
        .route_q       (route),
        .ien_q         (ien),
        .level_q       (level),
        .pol_q         (pol),
        .stat_clr_mask (clr_mask)
    );

    gpio_irq_sense u_sense (
        .clk      (clk),
        .rst      (rst),
        .cur      (din_sync),
        .route    (route),
        .level    (level),
        .pol      (pol),
        .ien      (ien),
        .clr_mask (clr_mask),
        .status_q (status),
        .irq_out  (irq_out)
    );

    // R1
    reset_out_chk: assert property (@(posedge clk)
        $past(rst) |-> (pin_out == '0 && pin_oe == '0 && !irq_out));
endmodule

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
    localparam real CLK_NS = 20.0;
    localparam int  NVEC   = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq_out;

    int nchk  = 0;
    int nfail = 0;
    logic [31:0] rv;

    always #(CLK_NS / 2.0) clk = ~clk;

    gpio_bank u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    // {req, write addr, write data, read addr, expected}
    localparam logic [87:0] VEC [NVEC] = '{
        {8'd2,  8'h00, 32'hA5A5_0F0F, 8'h00, 32'hA5A5_0F0F}, // R2 load
        {8'd3,  8'h04, 32'h0000_F0F0, 8'h00, 32'hA5A5_FFFF}, // R3 set
        {8'd4,  8'h08, 32'hA500_000F, 8'h00, 32'h00A5_FFF0}, // R4 clear
        {8'd5,  8'h0C, 32'hFFFF_FFFF, 8'h00, 32'h00A5_FFF0}, // R5 reserved form
        {8'd2,  8'h20, 32'h1234_5678, 8'h20, 32'h1234_5678}, // R2
        {8'd4,  8'h28, 32'h0000_0078, 8'h20, 32'h1234_5600}, // R4
        {8'd3,  8'h24, 32'h8000_0001, 8'h20, 32'h9234_5601}, // R3
        {8'd5,  8'h60, 32'h0000_00FF, 8'h68, 32'h0000_00FF}, // R5 read via alias
        {8'd3,  8'h64, 32'hFF00_0000, 8'h60, 32'hFF00_00FF}, // R3
        {8'd4,  8'h68, 32'hFFFF_FFFF, 8'h60, 32'h0000_0000}, // R4
        {8'd6,  8'h10, 32'hFFFF_FFFF, 8'h10, 32'h0000_0000}, // R6 read-only
        {8'd6,  8'h14, 32'hFFFF_FFFF, 8'h10, 32'h0000_0000}, // R6
        {8'd5,  8'h80, 32'hFFFF_FFFF, 8'h80, 32'h0000_0000}, // R5 out of range
        {8'd11, 8'h70, 32'hFFFF_FFFF, 8'h70, 32'h0000_0000}, // R11 load ignored
        {8'd11, 8'h74, 32'hFFFF_FFFF, 8'h70, 32'h0000_0000}, // R11 set ignored
        {8'd2,  8'h40, 32'h0000_0000, 8'h40, 32'h0000_0000}  // R2
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 200000.0);
        nchk++; nfail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk("R1", pin_out, 32'h0);
        chk("R1", pin_oe, 32'h0);
        chk("R1", {31'h0, irq_out}, 32'h0);
        for (int r = 0; r < 8; r++) begin
            rd(8'(r * 16), rv);
            chk("R1", rv, 32'h0);
        end

        // Register access table
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][79:72], VEC[i][71:40]);
            rd(VEC[i][39:32], rv);
            nchk++;
            if (rv !== VEC[i][31:0]) begin
                nfail++;
                $display("FAIL R%0d: vector %0d actual %h expected %h",
                         VEC[i][87:80], i, rv, VEC[i][31:0]);
            end
        end
        // R7 pads follow registers
        chk("R7", pin_out, 32'h00A5_FFF0);
        chk("R7", pin_oe, 32'h9234_5601);
        wr(8'h00, 32'h0); wr(8'h20, 32'h0);

        // R8 rising edge on pin 0, latency count
        wr(8'h30, 32'h1); wr(8'h60, 32'h1); wr(8'h40, 32'h1);
        chk("R12", {31'h0, irq_out}, 32'h0);
        pin_in[0] = 1'b1;
        tick(1);
        rd(8'h10, rv); chk("R6", rv, 32'h0);
        tick(1);
        rd(8'h10, rv); chk("R6", rv, 32'h1);
        rd(8'h70, rv); chk("R8", rv, 32'h0);
        tick(1);
        rd(8'h70, rv); chk("R8", rv, 32'h1);
        chk("R12", {31'h0, irq_out}, 32'h1);
        wr(8'h78, 32'h1);
        rd(8'h70, rv); chk("R11", rv, 32'h0);
        chk("R12", {31'h0, irq_out}, 32'h0);

        // R13 flip polarity while pin high, then falling edge
        wr(8'h68, 32'h1);
        tick(3);
        rd(8'h70, rv); chk("R13", rv, 32'h0);
        pin_in[0] = 1'b0;
        tick(4);
        rd(8'h70, rv); chk("R13", rv, 32'h1);
        wr(8'h78, 32'h1);
        // R8 falling polarity ignores rising edge
        pin_in[0] = 1'b1;
        tick(4);
        rd(8'h70, rv); chk("R8", rv, 32'h0);
        pin_in[0] = 1'b0;
        tick(4);
        rd(8'h70, rv); chk("R8", rv, 32'h1);
        // R11 load write to status ignored
        wr(8'h70, 32'h0);
        rd(8'h70, rv); chk("R11", rv, 32'h1);
        // R12 enable off hides status from irq
        wr(8'h48, 32'h1);
        chk("R12", {31'h0, irq_out}, 32'h0);
        rd(8'h70, rv); chk("R12", rv, 32'h1);
        wr(8'h78, 32'hFFFF_FFFF); wr(8'h30, 32'h0);

        // R9 level high on pin 2
        wr(8'h30, 32'h4); wr(8'h50, 32'h4); wr(8'h64, 32'h4); wr(8'h44, 32'h4);
        pin_in[2] = 1'b1;
        tick(4);
        rd(8'h70, rv); chk("R9", rv, 32'h4);
        wr(8'h78, 32'h4);
        rd(8'h70, rv); chk("R9", rv, 32'h4);
        chk("R9", {31'h0, irq_out}, 32'h1);
        pin_in[2] = 1'b0;
        tick(3);
        wr(8'h78, 32'h4);
        tick(2);
        rd(8'h70, rv); chk("R9", rv, 32'h0);
        chk("R12", {31'h0, irq_out}, 32'h0);

        // R9 level low on pin 3 (pin already low)
        wr(8'h54, 32'h8); wr(8'h34, 32'h8);
        tick(1);
        rd(8'h70, rv); chk("R9", rv, 32'h8);
        pin_in[3] = 1'b1;
        tick(3);
        wr(8'h78, 32'h8);
        rd(8'h70, rv); chk("R9", rv, 32'h0);

        // R10 unrouted pin 4 never latches
        wr(8'h44, 32'h10); wr(8'h64, 32'h10);
        pin_in[4] = 1'b1;
        tick(4);
        pin_in[4] = 1'b0;
        tick(4);
        rd(8'h70, rv); chk("R10", rv, 32'h0);
        chk("R10", {31'h0, irq_out}, 32'h0);

        // R1 reset mid-run
        wr(8'h00, 32'hFFFF_FFFF); wr(8'h20, 32'hFFFF_FFFF);
        @(negedge clk); rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(1);
        chk("R1", pin_out, 32'h0);
        chk("R1", pin_oe, 32'h0);
        rd(8'h60, rv); chk("R1", rv, 32'h0);
        rd(8'h30, rv); chk("R1", rv, 32'h0);

        summary();
    end
endmodule